// File: doc/BRIEF.md
# Machine Interrupt Pending Register

This block is the machine-level interrupt-pending status register of a small RISC-V-style core. It presents two kinds of interrupt source in one 32-bit word. Three standard sources (software, timer and external) appear as live mirrors of their request lines, and software cannot change them. Sixteen fast interrupt request channels each have a sticky flag. An input pulse sets the flag, and it stays set until software clears it with a write-one-to-clear access.

The core reads the word through a CSR port. The read is combinational in the cycle the read strobe is high. Write data is applied at the next clock edge. A write that touches read-only or unimplemented bits is accepted without any error indication, and those bits are left unchanged. A separate output gives the OR of all pending bits masked by an externally supplied enable word. The core's trap logic uses this output to decide whether an interrupt is waiting.

Top module: `irq_pend_csr`

## Requirements
- R1: After reset, every fast flag is clear. With all three standard lines low, a read at address 0x344 returns 0x00000000 and `irq_any` is 0.
- R2: If `fast_irq[n]` is high at a rising edge, word bit 16+n reads 1 from that edge on. It stays 1 after the input drops, until a clear of that bit.
- R3: A write at address 0x344 with write-data bit 16+n equal to 1 clears fast flag n at the edge. Flags whose write-data bit is 0 keep their value.
- R4: If `fast_irq[n]` is high at the same edge as a clearing write of bit 16+n, flag n is 1 after that edge.
- R5: Word bit 3 follows `sw_irq`, bit 7 follows `tmr_irq` and bit 11 follows `ext_irq`, in the same cycle. No write changes these bits.
- R6: Word bits 0-2, 4-6, 8-10 and 12-15 always read 0, whatever has been written.
- R7: A write at any address other than 0x344 leaves every fast flag unchanged.
- R8: `csr_rdata` is zero unless `csr_rd` is high with address 0x344. When both hold, `csr_rdata` carries the current word in that same cycle.
- R9: `irq_any` equals the OR over all bits of (current word AND `irq_enable`), evaluated combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_addr | input | 12 | CSR address of the current access |
| csr_rd | input | 1 | Read strobe |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | 32 | Write data; a 1 in bits 31:16 clears the matching flag |
| csr_rdata | output | 32 | Read data, zero when not selected |
| fast_irq | input | 16 | Fast request inputs, a high cycle sets the flag |
| sw_irq | input | 1 | Software interrupt request line |
| tmr_irq | input | 1 | Timer interrupt request line |
| ext_irq | input | 1 | External interrupt request line |
| irq_enable | input | 32 | Per-bit enable mask for `irq_any` |
| irq_any | output | 1 | Some pending bit is enabled |

## Verification
Two functions can fall in the same cycle: a fast request pulse setting a flag, and a software write clearing that same flag. The bench provokes the overlap on every channel by holding the request high during the clearing write. It does this once with the flag already set and once with it clear, and expects the flag to read 1 afterwards in both cases. The bench also sweeps each channel through set, hold and clear. It checks every standard-line combination and every single-bit enable mask against a word it builds from its own flag model.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

  localparam int XLEN      = 32;
  localparam int ADDR_W    = 12;
  localparam int FAST_N    = 16;
  localparam int FAST_LSB  = 16;
  localparam int SW_BIT    = 3;
  localparam int TMR_BIT   = 7;
  localparam int EXT_BIT   = 11;
  localparam logic [ADDR_W-1:0] PEND_ADDR = 12'h344;

  // Bit positions that carry state; all others are hard zero.
  function automatic logic [XLEN-1:0] impl_mask();
    logic [XLEN-1:0] m;
    m = '0;
    m[SW_BIT]  = 1'b1;
    m[TMR_BIT] = 1'b1;
    m[EXT_BIT] = 1'b1;
    for (int i = 0; i < FAST_N; i++) m[FAST_LSB+i] = 1'b1;
    return m;
  endfunction

  // Assemble the visible word from flags and standard lines.
  function automatic logic [XLEN-1:0] build_word(
    input logic [FAST_N-1:0] flags,
    input logic sw, input logic tmr, input logic ext);
    logic [XLEN-1:0] w;
    w = '0;
    w[SW_BIT]  = sw;
    w[TMR_BIT] = tmr;
    w[EXT_BIT] = ext;
    w[FAST_LSB +: FAST_N] = flags;
    return w;
  endfunction

  // Next state of the sticky flags: a request beats a clear.
  function automatic logic [FAST_N-1:0] next_flags(
    input logic [FAST_N-1:0] cur,
    input logic [FAST_N-1:0] clr,
    input logic [FAST_N-1:0] req);
    return (cur & ~clr) | req;
  endfunction

endpackage

// File: rtl/irq_pend_decode.sv
module irq_pend_decode
  import irq_pend_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = XLEN,
  parameter int NF = FAST_N,
  parameter int FL = FAST_LSB,
  parameter logic [AW-1:0] MY_ADDR = PEND_ADDR
) (
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic          rd_hit,
  output logic          wr_hit,
  output logic [NF-1:0] clr_mask
);
  logic sel;
  logic unused_wbits;

  assign sel      = (addr == MY_ADDR);
  assign rd_hit   = rd & sel;
  assign wr_hit   = wr & sel;
  assign clr_mask = wr_hit ? wdata[FL +: NF] : '0;

  // Bits outside the fast field are accepted and dropped silently.
  assign unused_wbits = ^{wdata};
endmodule

// File: rtl/irq_pend_fast.sv
module irq_pend_fast
  import irq_pend_pkg::*;
#(
  parameter int NF = FAST_N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] req,
  input  logic [NF-1:0] clr_mask,
  output logic [NF-1:0] flags
);
  logic [NF-1:0] flags_d;

  assign flags_d = next_flags(flags, clr_mask, req);

  for (genvar g = 0; g < NF; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[g] <= 1'b0;
      else        flags[g] <= flags_d[g];
    end
  end

  // R2 / R4: any request sampled at an edge is visible after it
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(req)) == $past(req)));

  // R2 / R7: a flag only falls when a clear was decoded for it
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~flags & $past(flags) & ~$past(clr_mask)) == '0));

  // R3: a cleared flag without a competing request reads zero
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(clr_mask & ~req)) == '0));
endmodule

// File: rtl/irq_pend_view.sv
module irq_pend_view
  import irq_pend_pkg::*;
#(
  parameter int DW = XLEN,
  parameter int NF = FAST_N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] flags,
  input  logic          sw,
  input  logic          tmr,
  input  logic          ext,
  input  logic          rd_hit,
  input  logic [DW-1:0] enable,
  output logic [DW-1:0] rdata,
  output logic          any
);
  logic [DW-1:0] word;

  assign word  = build_word(flags, sw, tmr, ext);
  assign rdata = rd_hit ? word : '0;
  assign any   = |(word & enable);

  // R6: unimplemented positions never show on the read port
  p_unimpl_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~impl_mask()) == '0);

  // R8: no data leaks without a selected read
  p_rd_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> (rdata == '0));

  // R5: standard lines appear unchanged on a selected read
  p_std_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> (rdata[SW_BIT] == sw && rdata[TMR_BIT] == tmr && rdata[EXT_BIT] == ext));

  // R2: selected read shows the flag field
  p_fast_view_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> (rdata[FAST_LSB +: NF] == flags));
endmodule

// File: rtl/irq_pend_csr.sv
module irq_pend_csr
  import irq_pend_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic              csr_rd,
  input  logic              csr_wr,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  input  logic [FAST_N-1:0] fast_irq,
  input  logic              sw_irq,
  input  logic              tmr_irq,
  input  logic              ext_irq,
  input  logic [XLEN-1:0]   irq_enable,
  output logic              irq_any
);
  logic              rd_hit;
  logic              wr_hit;
  logic [FAST_N-1:0] clr_mask;
  logic [FAST_N-1:0] flags;
  logic              unused_wr;

  assign unused_wr = wr_hit;

  irq_pend_decode #(
    .AW(ADDR_W), .DW(XLEN), .NF(FAST_N), .FL(FAST_LSB), .MY_ADDR(PEND_ADDR)
  ) u_dec (
    .addr(csr_addr), .rd(csr_rd), .wr(csr_wr), .wdata(csr_wdata),
    .rd_hit(rd_hit), .wr_hit(wr_hit), .clr_mask(clr_mask)
  );

  irq_pend_fast #(.NF(FAST_N)) u_fast (
    .clk(clk), .rst_n(rst_n), .req(fast_irq), .clr_mask(clr_mask), .flags(flags)
  );

  irq_pend_view #(.DW(XLEN), .NF(FAST_N)) u_view (
    .clk(clk), .rst_n(rst_n), .flags(flags), .sw(sw_irq), .tmr(tmr_irq),
    .ext(ext_irq), .rd_hit(rd_hit), .enable(irq_enable),
    .rdata(csr_rdata), .any(irq_any)
  );

  // R7: writes elsewhere decode no clear
  p_other_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr != PEND_ADDR) |-> (clr_mask == '0));
endmodule

// File: tb/sim_irq_pend_csr.sv
module sim_irq_pend_csr;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] csr_addr = '0;
  logic        csr_rd = 1'b0, csr_wr = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic [15:0] fast_irq = '0;
  logic        sw_irq = 1'b0, tmr_irq = 1'b0, ext_irq = 1'b0;
  logic [31:0] irq_enable = '0;
  logic        irq_any;

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_flags = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_pend_csr u0 (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_rd(csr_rd),
    .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .fast_irq(fast_irq), .sw_irq(sw_irq), .tmr_irq(tmr_irq),
    .ext_irq(ext_irq), .irq_enable(irq_enable), .irq_any(irq_any)
  );

  function automatic logic [31:0] exp_word(logic [15:0] f);
    return {f, 4'b0, ext_irq, 3'b0, tmr_irq, 3'b0, sw_irq, 3'b0};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
    csr_addr = a; csr_rd = 1'b1; #1;
    chk(tag, csr_rdata, exp);
    csr_rd = 1'b0; #1;
    chk({tag, " idle"}, csr_rdata, 32'h0);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [15:0] req);
    csr_addr = a; csr_wr = 1'b1; csr_wdata = d; fast_irq = req;
    step();
    csr_wr = 1'b0; csr_wdata = '0; fast_irq = '0;
    if (a == 12'h344) m_flags = (m_flags & ~d[31:16]) | req;
    else m_flags = m_flags | req;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    chk("R1 rdata at reset", csr_rdata, 32'h0);
    rst_n = 1'b1; step();
    rd_chk("R1 reset word", 12'h344, 32'h0);
    irq_enable = '1; #1;
    chk("R1 irq_any at reset", {31'b0, irq_any}, 32'h0);
    irq_enable = '0;

    // R2: set each channel by a one-cycle pulse, flag holds afterwards
    for (int n = 0; n < 16; n++) begin
      wr(12'h000, 32'h0, 16'h1 << n);
      step();
      rd_chk("R2 sticky set", 12'h344, exp_word(m_flags));
    end

    // R3: clear each bit alone; zeros leave others intact
    for (int n = 0; n < 16; n++) begin
      wr(12'h344, 32'h1 << (16 + n), 16'h0);
      rd_chk("R3 w1c single", 12'h344, exp_word(m_flags));
    end
    wr(12'h000, 32'h0, 16'hA5C3);
    wr(12'h344, 32'h0, 16'h0);
    rd_chk("R3 write zero keeps", 12'h344, exp_word(m_flags));
    wr(12'h344, 32'h0000_FFFF, 16'h0);
    rd_chk("R3 low-half write keeps", 12'h344, exp_word(m_flags));

    // R4: request and clear in the same cycle, flag set or clear beforehand
    for (int n = 0; n < 16; n++) begin
      wr(12'h344, 32'h1 << (16 + n), 16'h1 << n);
      chk("R4 set wins (flag was any)", {31'b0, m_flags[n]}, 32'h1);
      rd_chk("R4 set wins", 12'h344, exp_word(m_flags));
      wr(12'h344, 32'h1 << (16 + n), 16'h0);
      wr(12'h344, 32'h1 << (16 + n), 16'h1 << n);
      rd_chk("R4 set wins from clear", 12'h344, exp_word(m_flags));
    end

    // R7: writes elsewhere do not clear
    wr(12'h343, 32'hFFFF_FFFF, 16'h0);
    rd_chk("R7 other address", 12'h344, exp_word(m_flags));
    wr(12'hB44, 32'hFFFF_FFFF, 16'h0);
    rd_chk("R7 near address", 12'h344, exp_word(m_flags));

    // R5 / R6: every standard line combination, writes cannot touch them
    for (int c = 0; c < 8; c++) begin
      {ext_irq, tmr_irq, sw_irq} = 3'(c);
      #1;
      rd_chk("R5 std live", 12'h344, exp_word(m_flags));
      wr(12'h344, 32'h0000_FFFF, 16'h0);
      rd_chk("R6 unimpl after write", 12'h344, exp_word(m_flags));
    end

    // R8: read with wrong address returns zero
    rd_chk("R8 wrong address", 12'h345, 32'h0);

    // R9: single-bit enable sweep, then full mask
    {ext_irq, tmr_irq, sw_irq} = 3'b101;
    wr(12'h344, 32'hFFFF_0000, 16'h8001);
    for (int b = 0; b < 32; b++) begin
      irq_enable = 32'h1 << b; #1;
      chk("R9 masked any", {31'b0, irq_any}, {31'b0, |(exp_word(m_flags) & irq_enable)});
    end
    irq_enable = '1; #1;
    chk("R9 full mask", {31'b0, irq_any}, 32'h1);
    {ext_irq, tmr_irq, sw_irq} = 3'b000;
    wr(12'h344, 32'hFFFF_0000, 16'h0); #1;
    chk("R9 nothing pending", {31'b0, irq_any}, 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule